// File: doc/BRIEF.md
# Packed FP64 to INT32 Truncating Converter

This block turns packed IEEE-754 double-precision values into packed signed 32-bit integers. Each conversion rounds toward zero. A lane whose value does not fit in a signed 32-bit integer, and any NaN or infinity, yields the integer indefinite word 0x80000000 and raises the invalid flag.

A 2-bit mode input picks how results are packed and what happens to the upper destination bits. In mode 0, two lanes are converted and the upper half of the previous destination is kept. In mode 1, two lanes are converted and everything above the low 64 bits is cleared. In mode 2, four lanes are converted and the upper half is cleared. Mode 3 is undefined. In modes 1 and 2, a 4-bit reserved specifier must read all ones.

The block takes a valid strobe, the 256-bit source and the previous 256-bit destination value. One cycle later it returns the merged result with sticky invalid and inexact flags and a per-operation undefined-operation flag.

Top module: `fp64_trunc_pack`

## Requirements
- R1: An in-range lane gives its value truncated toward zero. ±0.0, denormals and magnitudes below 1.0 give 0.
- R2: A lane that is NaN, ±infinity, at or above +2^31, or at or below -2^31-1 gives 0x80000000 and sets the sticky invalid flag. The flag stays set until reset.
- R3: Values in the open interval (-2^31-1, -2^31) and -2^31 itself give 0x80000000 without invalid. 2147483647.9 gives 0x7FFFFFFF.
- R4: Source bits [64k+63:64k] of lane k convert into result bits [32k+31:32k].
- R5: Mode 0 (2'd0) converts lanes 0 and 1. It zeroes result bits [127:64] and copies prev_dst[255:128] into result bits [255:128]. It ignores the reserved specifier.
- R6: Mode 1 (2'd1) converts lanes 0 and 1 and zeroes result bits [255:64].
- R7: Mode 2 (2'd2) converts four lanes into bits [127:0] and zeroes bits [255:128].
- R8: The sticky inexact flag is set when an active lane that is not invalid drops nonzero fraction bits. Invalid lanes do not set it, and neither do lanes 2 and 3 in the two-lane modes. Lanes 2 and 3 also never set invalid in those modes.
- R9: The operation is undefined when mode is 1 or 2 with the reserved specifier other than 4'b1111, or when mode is 3. An undefined operation pulses flag_undef, returns prev_dst unchanged and leaves both sticky flags as they were.
- R10: out_valid, result and flag_undef update on the clock edge after in_valid is sampled high. While in_valid is low, out_valid is 0 and result holds.
- R11: After reset, result, out_valid and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | 0 pair-keep, 1 pair-clear, 2 quad, 3 undefined |
| rsv_spec | input | 4 | Reserved specifier, must be 4'b1111 in modes 1 and 2 |
| src | input | 256 | Four packed FP64 lanes |
| prev_dst | input | 256 | Previous destination value |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Merged destination value |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_inexact | output | 1 | Sticky precision flag |
| flag_undef | output | 1 | Undefined-operation flag for this result |

## Verification
Exact integers of both signs show whether packing and sign handling are right without involving rounding. Fractional values, denormals and -0.0 show whether truncation and the inexact rule are right. The values just inside and just outside both ends of the 32-bit range, together with NaN and infinity, separate a valid -2^31 from the indefinite produced by invalid inputs. Junk placed in the inactive lanes, bad reserved specifiers and mode 3 show that the flags and the destination stay untouched where they must.

// File: rtl/fp64tp_pkg.sv
package fp64tp_pkg;
  localparam int DBL_W = 64;
  localparam int INT_W = 32;
  localparam int EXP_W = 11;
  localparam int FRC_W = 52;
  localparam logic [INT_W-1:0] INDEF = 32'h8000_0000;

  typedef enum logic [1:0] {
    MD_PAIR_KEEP = 2'd0,
    MD_PAIR_CLR  = 2'd1,
    MD_QUAD      = 2'd2,
    MD_RSVD      = 2'd3
  } cvt_mode_e;

  typedef struct packed {
    logic [INT_W-1:0] word;
    logic             inv;
    logic             inx;
  } lane_out_t;

  // Truncating conversion of one double into a signed 32-bit word.
  function automatic lane_out_t cvt_lane(input logic [DBL_W-1:0] d);
    lane_out_t        r;
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [FRC_W-1:0] fr;
    logic [EXP_W-1:0] sh_full;
    logic [5:0]       sh;
    logic [FRC_W:0]   mant;
    logic [FRC_W:0]   mag;
    logic [FRC_W:0]   fmask;
    sgn     = d[63];
    ex      = d[62:52];
    fr      = d[51:0];
    r.word  = INDEF;
    r.inv   = 1'b1;
    r.inx   = 1'b0;
    sh_full = 11'd1075 - ex;
    sh      = sh_full[5:0];
    mant    = {1'b1, fr};
    mag     = mant >> sh;
    fmask   = (53'd1 << sh) - 53'd1;
    if (ex == 11'h7FF) begin
      r.inv = 1'b1;
    end else if (ex < 11'd1023) begin
      r.word = '0;
      r.inv  = 1'b0;
      r.inx  = (ex != '0) || (fr != '0);
    end else if (ex > 11'd1054) begin
      r.inv = 1'b1;
    end else if (ex == 11'd1054) begin
      // magnitude in [2^31, 2^32): only -2^31 after truncation is legal
      if (sgn && (fr[51:21] == '0)) begin
        r.word = INDEF;
        r.inv  = 1'b0;
        r.inx  = |fr[20:0];
      end
    end else begin
      r.inv  = 1'b0;
      r.inx  = |(mant & fmask);
      r.word = sgn ? (~mag[INT_W-1:0] + 32'd1) : mag[INT_W-1:0];
    end
    return r;
  endfunction

  // Reserved-field and mode legality check.
  function automatic logic is_undef(input logic [1:0] md, input logic [3:0] rsv);
    return (md == MD_RSVD) || ((md != MD_PAIR_KEEP) && (rsv != 4'hF));
  endfunction
endpackage

// File: rtl/fp64tp_lane.sv
module fp64tp_lane
  import fp64tp_pkg::*;
(
  input  logic [DBL_W-1:0] dbl,
  output logic [INT_W-1:0] word,
  output logic             inv,
  output logic             inx
);
  lane_out_t res;
  always_comb begin
    res  = cvt_lane(dbl);
    word = res.word;
    inv  = res.inv;
    inx  = res.inx;
  end
endmodule

// File: rtl/fp64tp_flags.sv
module fp64tp_flags #(
  parameter int LANES = 4
) (
  input  logic [1:0]       mode,
  input  logic [LANES-1:0] lane_inv,
  input  logic [LANES-1:0] lane_inx,
  output logic             any_inv,
  output logic             any_inx
);
  localparam int HALF = LANES / 2;
  logic [LANES-1:0] act;
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      act[i] = (mode == 2'd2) ? 1'b1 : (i < HALF);
    end
    any_inv = |(act & lane_inv);
    any_inx = |(act & lane_inx & ~lane_inv);
  end
endmodule

// File: rtl/fp64tp_pack.sv
module fp64tp_pack #(
  parameter int LANES = 4,
  parameter int INT_W = 32,
  parameter int DST_W = 256
) (
  input  logic [1:0]                  mode,
  input  logic                        undef,
  input  logic [LANES-1:0][INT_W-1:0] words,
  input  logic [DST_W-1:0]            prev_dst,
  output logic [DST_W-1:0]            dst
);
  localparam int HALF = LANES / 2;
  localparam int UPB  = DST_W / 2;
  always_comb begin
    dst = '0;
    if (undef) begin
      dst = prev_dst;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (mode == 2'd2 || i < HALF) dst[i*INT_W +: INT_W] = words[i];
      end
      if (mode == 2'd0) dst[DST_W-1:UPB] = prev_dst[DST_W-1:UPB];
    end
  end
endmodule

// File: rtl/fp64_trunc_pack.sv
module fp64_trunc_pack
  import fp64tp_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SRC_W = LANES * DBL_W,
  localparam int DST_W = SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [3:0]       rsv_spec,
  input  logic [SRC_W-1:0] src,
  input  logic [DST_W-1:0] prev_dst,
  output logic             out_valid,
  output logic [DST_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_inexact,
  output logic             flag_undef
);
  logic [LANES-1:0][INT_W-1:0] lane_word;
  logic [LANES-1:0]            lane_inv;
  logic [LANES-1:0]            lane_inx;
  logic                        op_undef;
  logic                        any_inv;
  logic                        any_inx;
  logic [DST_W-1:0]            merged;

  assign op_undef = is_undef(mode, rsv_spec);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp64tp_lane u_lane (
      .dbl  (src[g*DBL_W +: DBL_W]),
      .word (lane_word[g]),
      .inv  (lane_inv[g]),
      .inx  (lane_inx[g])
    );
  end

  fp64tp_flags #(.LANES(LANES)) u_flags (
    .mode     (mode),
    .lane_inv (lane_inv),
    .lane_inx (lane_inx),
    .any_inv  (any_inv),
    .any_inx  (any_inx)
  );

  fp64tp_pack #(.LANES(LANES), .INT_W(INT_W), .DST_W(DST_W)) u_pack (
    .mode     (mode),
    .undef    (op_undef),
    .words    (lane_word),
    .prev_dst (prev_dst),
    .dst      (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      flag_undef   <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      flag_undef <= in_valid & op_undef;
      if (in_valid) begin
        result <= merged;
        if (!op_undef) begin
          flag_invalid <= flag_invalid | any_inv;
          flag_inexact <= flag_inexact | any_inx;
        end
      end
    end
  end
endmodule

// File: rtl/fp64tp_checker.sv
module fp64tp_checker #(
  parameter int LANES = 4,
  parameter int DST_W = 256
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [1:0]             mode,
  input logic [DST_W-1:0]       prev_dst,
  input logic                   out_valid,
  input logic [DST_W-1:0]       result,
  input logic                   flag_invalid,
  input logic                   flag_inexact,
  input logic                   flag_undef,
  input logic                   op_undef,
  input logic [LANES-1:0][31:0] lane_word,
  input logic [LANES-1:0]       lane_inv,
  input logic [LANES-1:0]       lane_inx
);
  localparam int UPB = DST_W / 2;

  assert_out_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !flag_undef && $stable(result)));
  assert_undef_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_undef) |=> (flag_undef && result == $past(prev_dst)));
  assert_undef_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_undef) |=> ($stable(flag_invalid) && $stable(flag_inexact)));
  assert_keep_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_undef && mode == 2'd0) |=>
      (result[DST_W-1:UPB] == $past(prev_dst[DST_W-1:UPB]) && result[UPB-1:64] == '0));
  assert_clear_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_undef && mode == 2'd1) |=> (result[DST_W-1:64] == '0));
  assert_quad_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_undef && mode == 2'd2) |=> (result[DST_W-1:UPB] == '0));
  assert_sticky_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |=> flag_invalid);
  assert_sticky_inx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inexact |=> flag_inexact);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    assert_inv_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lane_inv[g] |-> (lane_word[g] == 32'h8000_0000));
    assert_inx_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(lane_inv[g] && lane_inx[g]));
  end
endmodule

bind fp64_trunc_pack fp64tp_checker #(.LANES(LANES), .DST_W(DST_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .mode         (mode),
  .prev_dst     (prev_dst),
  .out_valid    (out_valid),
  .result       (result),
  .flag_invalid (flag_invalid),
  .flag_inexact (flag_inexact),
  .flag_undef   (flag_undef),
  .op_undef     (op_undef),
  .lane_word    (lane_word),
  .lane_inv     (lane_inv),
  .lane_inx     (lane_inx)
);

// File: tb/fp64_trunc_pack_tb.sv
module fp64_trunc_pack_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = '0;
  logic [3:0]   rsv_spec = 4'hF;
  logic [255:0] src = '0;
  logic [255:0] prev_dst = '0;
  logic         out_valid;
  logic [255:0] result;
  logic         flag_invalid, flag_inexact, flag_undef;

  int n_chk = 0;
  int n_fail = 0;
  bit s_inv = 0;
  bit s_inx = 0;

  typedef struct {
    logic [255:0] res;
    bit inv; bit inx; bit und;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  fp64_trunc_pack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .rsv_spec(rsv_spec), .src(src), .prev_dst(prev_dst),
    .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact), .flag_undef(flag_undef)
  );

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void ref_lane(input logic [63:0] b, output logic [31:0] w,
                                   output bit inv, output bit inx);
    real r;
    integer i;
    w = 32'h8000_0000; inv = 1; inx = 0;
    if (b[62:52] != 11'h7FF) begin
      r = $bitstoreal(b);
      if (r < 2147483648.0 && r > -2147483649.0) begin
        i = $rtoi(r);
        w = i;
        inv = 0;
        inx = ($itor(i) != r);
      end
    end
  endfunction

  task automatic drive(logic [1:0] md, logic [3:0] rsv, logic [63:0] l0, logic [63:0] l1,
                       logic [63:0] l2, logic [63:0] l3, logic [255:0] prev, string tag);
    exp_t e;
    logic [31:0] w [4];
    bit iv [4];
    bit ix [4];
    bit und;
    int nl;
    ref_lane(l0, w[0], iv[0], ix[0]);
    ref_lane(l1, w[1], iv[1], ix[1]);
    ref_lane(l2, w[2], iv[2], ix[2]);
    ref_lane(l3, w[3], iv[3], ix[3]);
    und = (md == 2'd3) || (md != 2'd0 && rsv != 4'hF);
    nl = (md == 2'd2) ? 4 : 2;
    e.res = '0;
    if (und) e.res = prev;
    else begin
      for (int k = 0; k < nl; k++) begin
        e.res[k*32 +: 32] = w[k];
        if (iv[k]) s_inv = 1;
        else if (ix[k]) s_inx = 1;
      end
      if (md == 2'd0) e.res[255:128] = prev[255:128];
    end
    e.inv = s_inv; e.inx = s_inx; e.und = und; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1; mode = md; rsv_spec = rsv;
    src = {l3, l2, l1, l0}; prev_dst = prev;
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) chk(0, "R10 unexpected out_valid", 256'(out_valid), 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(result == e.res, {e.tag, " result"}, result, e.res);
        chk(flag_invalid == e.inv, {e.tag, " invalid R2"}, 256'(flag_invalid), 256'(e.inv));
        chk(flag_inexact == e.inx, {e.tag, " inexact R8"}, 256'(flag_inexact), 256'(e.inx));
        chk(flag_undef == e.und, {e.tag, " undef R9"}, 256'(flag_undef), 256'(e.und));
      end
    end
  end

  function automatic logic [63:0] d(real v);
    return $realtobits(v);
  endfunction

  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'hFFF0_0000_0000_0001;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] DENRM = 64'h0000_0000_0000_0001;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] pat, held;
    pat = {8{32'hA5C3_0F1E}};
    repeat (3) @(negedge clk);
    chk(result == '0 && !out_valid, "R11 reset result", result, 0);
    chk(!flag_invalid && !flag_inexact && !flag_undef, "R11 reset flags",
        {flag_invalid, flag_inexact, flag_undef}, 0);
    rst_n = 1;
    // inactive lanes carry NaN and fractions: no flags (R8)
    drive(2'd1, 4'hF, d(2.0), d(-3.0), QNAN, d(0.5), pat, "R6 R8 inactive lanes");
    drive(2'd0, 4'h0, d(1.5), d(-2.7), d(9.25), SNAN, pat, "R1 R4 R5 keep upper");
    drive(2'd1, 4'hF, d(100.0), d(-100.0), d(1.0), d(2.0), pat, "R6 exact pair");
    drive(2'd2, 4'hF, d(3.99), d(-0.5), d(2147483647.9), d(-2147483648.5), pat, "R3 R7 quad bounds");
    drive(2'd2, 4'hF, DENRM, NZERO, d(-2147483648.0), d(-2147483648.999), pat, "R1 R3 denorm negzero");
    drive(2'd1, 4'h7, QNAN, PINF, d(0.5), d(1.0), pat, "R9 bad specifier");
    drive(2'd3, 4'hF, QNAN, PINF, d(0.5), d(1.0), ~pat, "R9 mode three");
    drive(2'd2, 4'hE, d(1.0), d(2.0), d(3.0), d(4.0), pat, "R9 quad bad spec");
    drive(2'd2, 4'hF, d(2147483648.0), QNAN, NINF, d(-2147483649.0), pat, "R2 invalid lanes");
    drive(2'd0, 4'h3, d(65536.75), d(-12345678.0), d(0.0), d(0.0), ~pat, "R5 spec ignored");
    drive(2'd2, 4'hF, d(7.0), d(-8.0), d(123456789.0), d(-1.0), pat, "R4 R7 lane order");
    repeat (3) @(negedge clk);
    held = result;
    repeat (4) @(negedge clk);
    chk(result == held && !out_valid, "R10 hold while idle", result, held);
    chk(sb.size() == 0, "R10 all results seen", 256'(sb.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule